// File: doc/BRIEF.md
# Pixel hybrid time-stamp counter

This block is the digital part of one detector pixel. When the discriminator output `hit` rises, it records when that happened and for how long the signal stayed above threshold. The arrival time has two parts. A 4-bit fine counter runs on the local fast clock, which is phase aligned with the slow clock and runs at exactly 16 times its rate. It measures the gap between the hit and the next slow-clock rising edge. A 12-bit coarse counter runs on the slow clock from that edge until the shared stop line `com_stop` is sampled high. An 8-bit counter measures time over threshold in slow-clock periods.

Every counter is a maximal-length LFSR, so no adder carry chain is needed. When `rd_mode` is high, counting stops and the three counters form one 24-bit shift chain. The chain moves one bit per slow clock while `token` is held and is read at `ser_out`. Only the first qualified hit after reset is recorded, and the `mask` input suppresses hits completely.

The fast domain has one state machine with the states IDLE, RUN and HOLD:
- IDLE goes to RUN on a qualified hit (start).
- IDLE or RUN goes to HOLD once the slow side has taken the hit (edge seen).
- HOLD stays there until reset.

The slow domain has one state machine with the states ARMED, BOTH, CRS_ONLY, TOT_ONLY and DONE:
- ARMED goes to BOTH on a qualified hit (arm), or to TOT_ONLY if the stop line is sampled high on the same edge.
- BOTH goes to CRS_ONLY when the hit falls (tot end).
- BOTH goes to TOT_ONLY when the stop line is sampled high (stop).
- BOTH goes to DONE when both happen on the same edge.
- CRS_ONLY goes to DONE on stop, and TOT_ONLY goes to DONE on tot end.
- DONE stays there until reset.
- While `rd_mode` is high, no transition is taken.

Top module: `pixel_stamp`

## Requirements
- R1: After reset, every counter holds the seed value 1 (only bit 0 set). A readout taken straight after reset returns fine=0x1, coarse=0x001 and tot=0x01.
- R2: A counting step shifts the register one place toward the MSB. The new bit 0 is the XOR of the tap bits:
  - fine: bits 3 and 2
  - coarse: bits 11, 5, 3 and 0
  - tot: bits 7, 5, 4 and 3
  A counter's value after n steps is the seed advanced n times by this rule.
- R3: The fine counter takes one step for each fast rising edge after the hit rises, up to and including the first slow rising edge that samples the hit high.
- R4: The coarse counter takes one step for each slow rising edge after the edge that took the hit, up to and excluding the first edge that samples `com_stop` high.
- R5: The tot counter takes one step for each slow rising edge after the edge that took the hit that still samples the hit high. It freezes at the first edge that samples the hit low.
- R6: A counter that reaches its terminal state holds that state until reset, whatever further steps are requested. The terminal state has only the MSB set and is reached after 2^W-2 steps.
- R7: Only the first qualified hit after reset is recorded. Later hits change no counter.
- R8: While `mask` is high, a hit starts no counter, and all three counters keep their seed values.
- R9: With `rd_mode` and `token` both high, each slow rising edge shifts the chain by one bit. The 24 bits appear at `ser_out` in this order: fine MSB to LSB, then coarse MSB to LSB, then tot MSB to LSB. With `token` low, `ser_out` does not change.
- R10: A slow edge that samples `rd_mode` high adds no step to the coarse or tot counter. Counting resumes once `rd_mode` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow time-base clock |
| clk_fast | input | 1 | Local fast clock, 16x slow, phase aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| hit | input | 1 | Discriminator output |
| mask | input | 1 | Configuration mask bit, high suppresses hits |
| com_stop | input | 1 | Shared stop line that ends the coarse count |
| rd_mode | input | 1 | High selects readout mode and freezes counting |
| token | input | 1 | Shift enable while in readout mode |
| ser_in | input | 1 | Serial input to the tot end of the chain |
| ser_out | output | 1 | Serial output from the fine end of the chain |

## Verification
The assertions assume the following about the inputs:
- The two clocks are phase aligned with a ratio of exactly 16.
- `hit`, `com_stop`, `rd_mode` and `token` change away from every clock edge.
- Once `hit` rises, it stays high across at least one slow rising edge, so both domains see the same hit.

The stimulus follows these assumptions. It raises `hit` on a fast falling edge at a known fast-bin offset after a slow edge. It changes every other input in the middle of a slow period, and it releases reset only in the middle of a slow period. Results are read only through the serial chain and compared with LFSR states that the bench computes from the step counts.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
    localparam int FINE_W_D = 4;
    localparam int CRS_W_D  = 12;
    localparam int TOT_W_D  = 8;

    localparam logic [FINE_W_D-1:0] FINE_TAPS_D = 4'b1100;
    localparam logic [CRS_W_D-1:0]  CRS_TAPS_D  = 12'b1000_0010_1001;
    localparam logic [TOT_W_D-1:0]  TOT_TAPS_D  = 8'b1011_1000;

    typedef enum logic [1:0] {
        F_IDLE,
        F_RUN,
        F_HOLD
    } fine_st_e;

    typedef enum logic [2:0] {
        S_ARMED,
        S_BOTH,
        S_CRS_ONLY,
        S_TOT_ONLY,
        S_DONE
    } slow_st_e;
endpackage

// File: rtl/tsc_lfsr_cell.sv
`timescale 1ns/1ps
module tsc_lfsr_cell #(
    parameter int           W    = 4,
    parameter logic [W-1:0] TAPS = 4'b1100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         shift_en,
    input  logic         ser_i,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] SEED = W'(1);
    localparam logic [W-1:0] TERM = W'(1) << (W - 1);

    logic fb;
    assign fb = ^(q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (shift_en) begin
            q <= {q[W-2:0], ser_i};
        end else if (cnt_en && (q != TERM)) begin
            q <= {q[W-2:0], fb};
        end
    end

    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !shift_en && q == TERM) |=> (q == TERM));

    a_r2_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !shift_en && q != '0) |=> (q != '0));
endmodule

// File: rtl/tsc_fine_tdc.sv
`timescale 1ns/1ps
module tsc_fine_tdc
    import tsc_pkg::*;
#(
    parameter int           W    = FINE_W_D,
    parameter logic [W-1:0] TAPS = FINE_TAPS_D
) (
    input  logic         clk_fast,
    input  logic         rst_n,
    input  logic         hit_ok,
    input  logic         edge_seen,
    output logic [W-1:0] fine_q
);
    fine_st_e st, st_nxt;
    logic     step;

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        step   = 1'b0;
        unique case (st)
            F_IDLE: begin
                if (edge_seen) begin
                    st_nxt = F_HOLD;
                end else if (hit_ok) begin
                    st_nxt = F_RUN;
                    step   = 1'b1;
                end
            end
            F_RUN: begin
                if (edge_seen) st_nxt = F_HOLD;
                else           step   = 1'b1;
            end
            F_HOLD: st_nxt = F_HOLD;
            default: st_nxt = F_HOLD;
        endcase
    end

    tsc_lfsr_cell #(.W(W), .TAPS(TAPS)) u_fine (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .cnt_en   (step),
        .shift_en (1'b0),
        .ser_i    (1'b0),
        .q        (fine_q)
    );

    a_r7_fine_frozen: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st == F_HOLD) |=> (st == F_HOLD && $stable(fine_q)));

    a_r3_idle_quiet: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st == F_IDLE && !hit_ok) |=> $stable(fine_q));
endmodule

// File: rtl/tsc_slow_ctrl.sv
`timescale 1ns/1ps
module tsc_slow_ctrl
    import tsc_pkg::*;
(
    input  logic clk_slow,
    input  logic rst_n,
    input  logic hit,
    input  logic hit_ok,
    input  logic stop,
    input  logic rd_mode,
    output logic crs_en,
    output logic tot_en,
    output logic armed
);
    slow_st_e st, st_nxt;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) st <= S_ARMED;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (!rd_mode) begin
            unique case (st)
                S_ARMED: begin
                    if (hit_ok) st_nxt = stop ? S_TOT_ONLY : S_BOTH;
                end
                S_BOTH: begin
                    if (stop && !hit)  st_nxt = S_DONE;
                    else if (stop)     st_nxt = S_TOT_ONLY;
                    else if (!hit)     st_nxt = S_CRS_ONLY;
                end
                S_CRS_ONLY: if (stop) st_nxt = S_DONE;
                S_TOT_ONLY: if (!hit) st_nxt = S_DONE;
                S_DONE:     st_nxt = S_DONE;
                default:    st_nxt = S_DONE;
            endcase
        end
    end

    always_comb begin
        armed  = (st == S_ARMED);
        crs_en = 1'b0;
        tot_en = 1'b0;
        if (!rd_mode) begin
            unique case (st)
                S_BOTH: begin
                    crs_en = !stop;
                    tot_en = hit;
                end
                S_CRS_ONLY: crs_en = !stop;
                S_TOT_ONLY: tot_en = hit;
                default: begin
                    crs_en = 1'b0;
                    tot_en = 1'b0;
                end
            endcase
        end
    end

    a_r7_one_shot: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !armed |=> !armed);

    a_r8_stay_armed: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (armed && !hit_ok) |=> armed);

    a_r10_freeze: assert property (@(posedge clk_slow) disable iff (!rst_n)
        rd_mode |=> $stable(st));

    a_r4_stop_ends: assert property (@(posedge clk_slow) disable iff (!rst_n)
        ((st == S_BOTH || st == S_CRS_ONLY) && stop && !rd_mode)
            |=> (st == S_TOT_ONLY || st == S_DONE));
endmodule

// File: rtl/pixel_stamp.sv
`timescale 1ns/1ps
module pixel_stamp
    import tsc_pkg::*;
#(
    parameter int                FINE_W    = FINE_W_D,
    parameter int                CRS_W     = CRS_W_D,
    parameter int                TOT_W     = TOT_W_D,
    parameter logic [FINE_W-1:0] FINE_TAPS = FINE_TAPS_D,
    parameter logic [CRS_W-1:0]  CRS_TAPS  = CRS_TAPS_D,
    parameter logic [TOT_W-1:0]  TOT_TAPS  = TOT_TAPS_D
) (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic rst_n,
    input  logic hit,
    input  logic mask,
    input  logic com_stop,
    input  logic rd_mode,
    input  logic token,
    input  logic ser_in,
    output logic ser_out
);
    localparam logic [FINE_W-1:0] FINE_SEED = FINE_W'(1);

    logic              hit_ok, shift, armed, crs_en, tot_en;
    logic [FINE_W-1:0] fine_q, fine_sh;
    logic [CRS_W-1:0]  crs_q;
    logic [TOT_W-1:0]  tot_q;

    assign hit_ok = hit & ~mask;
    assign shift  = rd_mode & token;

    tsc_fine_tdc #(.W(FINE_W), .TAPS(FINE_TAPS)) u_fine (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .hit_ok    (hit_ok),
        .edge_seen (!armed),
        .fine_q    (fine_q)
    );

    tsc_slow_ctrl u_ctrl (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .hit      (hit),
        .hit_ok   (hit_ok),
        .stop     (com_stop),
        .rd_mode  (rd_mode),
        .crs_en   (crs_en),
        .tot_en   (tot_en),
        .armed    (armed)
    );

    tsc_lfsr_cell #(.W(CRS_W), .TAPS(CRS_TAPS)) u_crs (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .cnt_en   (crs_en),
        .shift_en (shift),
        .ser_i    (tot_q[TOT_W-1]),
        .q        (crs_q)
    );

    tsc_lfsr_cell #(.W(TOT_W), .TAPS(TOT_TAPS)) u_tot (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .cnt_en   (tot_en),
        .shift_en (shift),
        .ser_i    (ser_in),
        .q        (tot_q)
    );

    // Slow-side stage of the fine count: follows the frozen fine value while
    // counting, becomes the head of the serial chain in readout mode.
    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n)       fine_sh <= FINE_SEED;
        else if (!rd_mode) fine_sh <= fine_q;
        else if (token)   fine_sh <= {fine_sh[FINE_W-2:0], crs_q[CRS_W-1]};
    end

    assign ser_out = fine_sh[FINE_W-1];

    a_r9_no_token: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (rd_mode && !token) |=> $stable(ser_out));
endmodule

// File: tb/pixel_stamp_test.sv
`timescale 1ns/1ps
module pixel_stamp_test;
    logic clk_slow, clk_fast, rst_n;
    logic hit, mask, com_stop, rd_mode, token, ser_in, ser_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [3:0]  f;
        logic [11:0] c;
        logic [7:0]  t;
        string       tf, tc, tt;
    } item_t;

    item_t       exp_q[$];
    logic [23:0] got_word;
    event        got_ev;

    pixel_stamp uut (
        .clk_slow (clk_slow), .clk_fast (clk_fast), .rst_n (rst_n),
        .hit (hit), .mask (mask), .com_stop (com_stop),
        .rd_mode (rd_mode), .token (token), .ser_in (ser_in),
        .ser_out (ser_out)
    );

    initial begin
        clk_slow = 1'b0;
        forever #10 clk_slow = ~clk_slow;
    end
    initial begin
        clk_fast = 1'b1;
        forever #0.625 clk_fast = ~clk_fast;
    end

    // LFSR advance with hold at the terminal state (R2, R6)
    function automatic logic [11:0] adv(int w, logic [11:0] taps, int n);
        logic [11:0] q, term, msk;
        q    = 12'd1;
        term = 12'd1 << (w - 1);
        msk  = (12'd1 << w) - 12'd1;
        for (int i = 0; i < n; i++) begin
            if (q == term) break;
            q = ((q << 1) | {11'd0, ^(q & taps)}) & msk;
        end
        return q;
    endfunction

    task automatic chk(string tag, string what, int got, int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s %s: got=0x%0h exp=0x%0h", tag, what, got, expv);
        end
    endtask

    // monitor: pops the expected item when a readout completes
    always @(got_ev) begin
        item_t it;
        if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R9 readout without expectation: got=0x%0h exp=none", got_word);
        end else begin
            it = exp_q.pop_front();
            chk(it.tf, "fine",   int'(got_word[23:20]), int'(it.f));
            chk(it.tc, "coarse", int'(got_word[19:8]),  int'(it.c));
            chk(it.tt, "tot",    int'(got_word[7:0]),   int'(it.t));
        end
    end

    task automatic do_reset();
        @(posedge clk_slow); #5;
        rst_n = 1'b0; hit = 1'b0; com_stop = 1'b0; rd_mode = 1'b0; token = 1'b0;
        repeat (2) @(posedge clk_slow);
        #5 rst_n = 1'b1;
    endtask

    // called at mid slow period; shifts out 24 bits
    task automatic readout(int token_wait);
        logic [23:0] w;
        rd_mode = 1'b1;
        token   = 1'b0;
        repeat (token_wait) begin
            @(posedge clk_slow); #5;
        end
        token = 1'b1;
        w[23] = ser_out;
        for (int i = 22; i >= 0; i--) begin
            @(posedge clk_slow); #5;
            w[i] = ser_out;
        end
        rd_mode = 1'b0; token = 1'b0;
        got_word = w;
        ->got_ev;
        #1;
    endtask

    // driver: one hit event, pushes the expected item, then reads out
    task automatic run_hit(int j, int n, int m, bit msk, bit rehit,
                           int rf, int rt, int tw, string tf, string tc, string tt);
        item_t it;
        int    last, wc, wt;
        wc = 0; wt = 0;
        for (int c = rf; c <= rt && rf > 0; c++) begin
            if (c <= n) wc++;
            if (c <= m) wt++;
        end
        it.f  = msk ? 4'd1   : adv(4, 12'h00C, 16 - j)[3:0];
        it.c  = msk ? 12'd1  : adv(12, 12'h829, n - wc);
        it.t  = msk ? 8'd1   : adv(8, 12'h0B8, m - wt)[7:0];
        it.tf = tf; it.tc = tc; it.tt = tt;
        exp_q.push_back(it);

        mask = msk;
        @(posedge clk_slow);
        #(0.625 + 1.25 * j) hit = 1'b1;
        @(posedge clk_slow);              // edge that takes the hit
        #5;
        last = ((n > m) ? n : m) + 2;
        for (int c = 1; c <= last; c++) begin
            @(posedge clk_slow); #5;
            if (c == m) hit = 1'b0;
            if (c == n) com_stop = 1'b1;
            if (rf > 0 && c == rf - 1) rd_mode = 1'b1;
            if (rf > 0 && c == rt) rd_mode = 1'b0;
        end
        com_stop = 1'b0;
        if (rehit) begin
            @(posedge clk_slow); #3 hit = 1'b1;
            repeat (4) @(posedge clk_slow);
            #5 hit = 1'b0;
            com_stop = 1'b1;
            repeat (3) @(posedge clk_slow);
            #5 com_stop = 1'b0;
        end
        @(posedge clk_slow); #5;
        readout(tw);
        mask = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hit = 1'b0; mask = 1'b0; com_stop = 1'b0;
        rd_mode = 1'b0; token = 1'b0; ser_in = 1'b0;
        #25 rst_n = 1'b1;

        // R1: readout straight after reset returns seeds
        begin
            item_t it;
            it.f = 4'd1; it.c = 12'd1; it.t = 8'd1;
            it.tf = "R1"; it.tc = "R1"; it.tt = "R1";
            exp_q.push_back(it);
            @(posedge clk_slow); #5;
            readout(0);
        end

        // R3/R6: 16 fine steps saturate at 0x8
        do_reset(); run_hit(0, 6, 4, 0, 0, 0, 0, 0, "R6", "R4", "R5");
        // R6: exactly 14 fine steps reach terminal state
        do_reset(); run_hit(2, 3, 8, 0, 0, 0, 0, 0, "R6", "R4", "R5");
        // R3: 13 fine steps
        do_reset(); run_hit(3, 9, 2, 0, 0, 0, 0, 0, "R3", "R4", "R5");
        // R2: mid-range values in every counter
        do_reset(); run_hit(7, 20, 11, 0, 0, 0, 0, 0, "R2", "R2", "R2");
        // R3: hit one fast bin before the slow edge
        do_reset(); run_hit(15, 1, 1, 0, 0, 0, 0, 0, "R3", "R4", "R5");
        // R8: masked hit leaves seeds
        do_reset(); run_hit(5, 6, 4, 1, 0, 0, 0, 0, "R8", "R8", "R8");
        // R7: second hit ignored
        do_reset(); run_hit(10, 5, 3, 0, 1, 0, 0, 0, "R7", "R7", "R7");
        // R9: token held low first, then shifted in order
        do_reset(); run_hit(4, 7, 5, 0, 0, 0, 0, 3, "R9", "R9", "R9");
        // R10: rd_mode window freezes coarse and tot for 5 edges
        do_reset(); run_hit(6, 10, 12, 0, 0, 3, 7, 0, "R3", "R10", "R10");
        // R6: coarse and tot overflow markers
        do_reset(); run_hit(8, 4100, 300, 0, 0, 0, 0, 0, "R3", "R6", "R6");

        #20;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule